// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the 8-bit processor status word of a small 8-bit core and computes the arithmetic result and flags that feed it. Each cycle the core presents two operands and an operation class. When the instruction executes, the block forms the result and the zero, digit-carry and carry flags, and stores the flags that the operation class affects. The same status word can also be the destination of an instruction. In that case a bit-by-bit write mask decides which written bits land. Flags produced by the instruction win over the written data. The two power-state bits never take written data.

The two power-state bits, time-out and power-down, follow only the watchdog-clear, sleep-entry and watchdog time-out event pulses and the power-on reset. The bank-select bit is exported for direct addressing. The two reserved upper bits always read zero.

Status bit positions, from bit 7 down to bit 0: reserved, reserved, bank select, time-out, power-down, zero, digit carry, carry.

Top module: `statusFlagReg`

## Requirements
- R1: After reset (rstN low) the status reads 8'h18: time-out (bit 4) and power-down (bit 3) are 1, and every other bit is 0.
- R2: Bits 7 and 6 always read 0. Writing 1 to them has no effect.
- R3: A write (wrEn) always loads bank select (bit 5) from wrData bit 5. bankSel equals bit 5, where 1 selects the upper bank.
- R4: Time-out and power-down ignore writes. They keep their value in every cycle with no event pulse.
- R5: wdtClear sets both time-out and power-down. sleepEnter sets time-out and clears power-down. wdtTimeout clears time-out and beats sleepEnter and wdtClear for that bit. sleepEnter beats wdtClear for power-down.
- R6: For add, subtract, AND, OR, XOR and clear, the zero flag (bit 2) is stored as 1 exactly when the 8-bit result is zero.
- R7: Add (opClass 1) returns opA+opB. Carry (bit 0) is the carry out of bit 7 and digit carry (bit 1) is the carry out of bit 3.
- R8: Subtract (opClass 2) returns opA-opB, computed as opA plus the two's complement of opB. Carry is 1 when opA>=opB, digit carry is 1 when opA[3:0]>=opB[3:0], and both read 0 on a borrow.
- R9: Rotate left (opClass 3) returns {opA[6:0],C} and loads C from opA[7]. Rotate right (opClass 4) returns {C,opA[7:1]} and loads C from opA[0]. Zero and digit carry are unchanged.
- R10: AND (5), OR (6) and XOR (7) update only the zero flag. Move (0) returns opA and updates no flag.
- R11: When a write coincides with an executing operation that affects any flag, the written values for bits 2..0 are discarded. Affected flags take the computed values and unaffected flags keep their value. Clear (opClass 8) with wrData 0 gives the pattern 000uu1uu.
- R12: A write together with a move, or with no executing operation, loads bits 2..0 from wrData.
- R13: When aluValid is low, no flag changes even if an operation class is presented, and aluResult still shows the combinational result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| opA | input | 8 | First operand, rotate source |
| opB | input | 8 | Second operand |
| opClass | input | 4 | Operation class: 0 move, 1 add, 2 sub, 3 rotate left, 4 rotate right, 5 AND, 6 OR, 7 XOR, 8 clear |
| aluValid | input | 1 | Instruction executes this cycle, so its flags are stored |
| wrEn | input | 1 | Status register is the instruction destination |
| wrData | input | 8 | Data written to the status register |
| wdtClear | input | 1 | Watchdog-clear instruction pulse |
| sleepEnter | input | 1 | Sleep instruction pulse |
| wdtTimeout | input | 1 | Watchdog time-out pulse |
| statusOut | output | 8 | Status register value |
| aluResult | output | 8 | Combinational ALU result |
| bankSel | output | 1 | Bank select for direct addressing |

## Verification
The assertions assume that opClass holds one of the nine defined codes whenever aluValid is high. They also assume that the event pulses are single-cycle signals sampled at the clock edge, so that the priority among simultaneous events is the only ordering that matters. The stimulus drives only defined class codes and changes every input at the falling edge. It combines events only in the pairs whose outcome R5 fixes, and it applies writes both with and without a flag-producing operation, so that the mask is seen in both states.

// File: rtl/statusFlagPkg.sv
package statusFlagPkg;

  localparam int STAT_W  = 8;
  localparam int BIT_C   = 0;
  localparam int BIT_DC  = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_PD  = 3;
  localparam int BIT_TO  = 4;
  localparam int BIT_RP0 = 5;

  typedef enum logic [3:0] {
    OP_MOV = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_RLF = 4'd3,
    OP_RRF = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_CLR = 4'd8
  } opClassE;

  // strobes from control to datapath
  typedef struct packed {
    logic updZ;
    logic updDc;
    logic updC;
    logic wrRp0;
    logic wrZ;
    logic wrDc;
    logic wrC;
    logic setTo;
    logic clrTo;
    logic setPd;
    logic clrPd;
  } strobeT;

endpackage

// File: rtl/statusFlagAlu.sv
module statusFlagAlu
  import statusFlagPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  opClassE           opClass,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              digitCarry,
  output logic              zero
);

  logic              subMode;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sumBits;
  logic              sumCarry;
  logic              sumDigit;

  assign subMode = (opClass == OP_SUB);
  assign addend  = subMode ? ~opB : opB;

  // ripple carry chain; the carry past the nibble boundary is tapped
  always_comb begin
    logic c;
    c        = subMode;
    sumDigit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      sumBits[i] = opA[i] ^ addend[i] ^ c;
      c          = (opA[i] & addend[i]) | (c & (opA[i] ^ addend[i]));
      if (i == NIB_W - 1) sumDigit = c;
    end
    sumCarry = c;
  end

  always_comb begin
    result     = opA;
    carryOut   = carryIn;
    digitCarry = sumDigit;
    unique case (opClass)
      OP_ADD, OP_SUB: begin
        result   = sumBits;
        carryOut = sumCarry;
      end
      OP_RLF: begin
        result   = {opA[DATA_W-2:0], carryIn};
        carryOut = opA[DATA_W-1];
      end
      OP_RRF: begin
        result   = {carryIn, opA[DATA_W-1:1]};
        carryOut = opA[0];
      end
      OP_AND:  result = opA & opB;
      OP_OR:   result = opA | opB;
      OP_XOR:  result = opA ^ opB;
      OP_CLR:  result = '0;
      default: result = opA;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/statusFlagCtrl.sv
module statusFlagCtrl
  import statusFlagPkg::*;
(
  input  opClassE opClass,
  input  logic    aluValid,
  input  logic    wrEn,
  input  logic    wdtClear,
  input  logic    sleepEnter,
  input  logic    wdtTimeout,
  output strobeT  strobe
);

  logic affZ;
  logic affDc;
  logic affC;
  logic anyFlag;

  always_comb begin
    affZ  = 1'b0;
    affDc = 1'b0;
    affC  = 1'b0;
    unique case (opClass)
      OP_ADD, OP_SUB: begin
        affZ  = 1'b1;
        affDc = 1'b1;
        affC  = 1'b1;
      end
      OP_RLF, OP_RRF:                 affC = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_CLR:  affZ = 1'b1;
      default: ;
    endcase
  end

  assign anyFlag = aluValid & (affZ | affDc | affC);

  always_comb begin
    strobe       = '0;
    strobe.updZ  = aluValid & affZ;
    strobe.updDc = aluValid & affDc;
    strobe.updC  = aluValid & affC;
    strobe.wrRp0 = wrEn;
    // one flag-producing operation masks all three flag bits from the write
    strobe.wrZ   = wrEn & ~anyFlag;
    strobe.wrDc  = wrEn & ~anyFlag;
    strobe.wrC   = wrEn & ~anyFlag;
    strobe.clrTo = wdtTimeout;
    strobe.setTo = (wdtClear | sleepEnter) & ~wdtTimeout;
    strobe.clrPd = sleepEnter;
    strobe.setPd = wdtClear & ~sleepEnter;
  end

endmodule

// File: rtl/statusFlagData.sv
module statusFlagData
  import statusFlagPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  opClassE           opClass,
  input  logic [STAT_W-1:0] wrData,
  input  strobeT            strobe,
  output logic [STAT_W-1:0] statusOut,
  output logic [DATA_W-1:0] aluResult
);

  logic rp0Q;
  logic toQ;
  logic pdQ;
  logic zQ;
  logic dcQ;
  logic cQ;
  logic aluCarry;
  logic aluDigit;
  logic aluZero;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[STAT_W-1:BIT_RP0+1], wrData[BIT_TO], wrData[BIT_PD]};

  statusFlagAlu #(.DATA_W(DATA_W), .NIB_W(NIB_W)) aluInst (
    .opA        (opA),
    .opB        (opB),
    .opClass    (opClass),
    .carryIn    (cQ),
    .result     (aluResult),
    .carryOut   (aluCarry),
    .digitCarry (aluDigit),
    .zero       (aluZero)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rp0Q <= 1'b0;
      toQ  <= 1'b1;
      pdQ  <= 1'b1;
      zQ   <= 1'b0;
      dcQ  <= 1'b0;
      cQ   <= 1'b0;
    end else begin
      if (strobe.wrRp0) rp0Q <= wrData[BIT_RP0];

      if (strobe.clrTo)      toQ <= 1'b0;
      else if (strobe.setTo) toQ <= 1'b1;

      if (strobe.clrPd)      pdQ <= 1'b0;
      else if (strobe.setPd) pdQ <= 1'b1;

      if (strobe.updZ)     zQ <= aluZero;
      else if (strobe.wrZ) zQ <= wrData[BIT_Z];

      if (strobe.updDc)     dcQ <= aluDigit;
      else if (strobe.wrDc) dcQ <= wrData[BIT_DC];

      if (strobe.updC)     cQ <= aluCarry;
      else if (strobe.wrC) cQ <= wrData[BIT_C];
    end
  end

  always_comb begin
    statusOut          = '0;
    statusOut[BIT_RP0] = rp0Q;
    statusOut[BIT_TO]  = toQ;
    statusOut[BIT_PD]  = pdQ;
    statusOut[BIT_Z]   = zQ;
    statusOut[BIT_DC]  = dcQ;
    statusOut[BIT_C]   = cQ;
  end

endmodule

// File: rtl/statusFlagReg.sv
module statusFlagReg
  import statusFlagPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        opClass,
  input  logic              aluValid,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              wdtClear,
  input  logic              sleepEnter,
  input  logic              wdtTimeout,
  output logic [7:0]        statusOut,
  output logic [DATA_W-1:0] aluResult,
  output logic              bankSel
);

  opClassE opSel;
  strobeT  strobe;

  assign opSel = opClassE'(opClass);

  statusFlagCtrl ctrlInst (
    .opClass    (opSel),
    .aluValid   (aluValid),
    .wrEn       (wrEn),
    .wdtClear   (wdtClear),
    .sleepEnter (sleepEnter),
    .wdtTimeout (wdtTimeout),
    .strobe     (strobe)
  );

  statusFlagData #(.DATA_W(DATA_W), .NIB_W(NIB_W)) dataInst (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .opClass   (opSel),
    .wrData    (wrData),
    .strobe    (strobe),
    .statusOut (statusOut),
    .aluResult (aluResult)
  );

  assign bankSel = statusOut[BIT_RP0];

endmodule

// File: rtl/statusFlagChk.sv
module statusFlagChk
  import statusFlagPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        opClass,
  input logic              aluValid,
  input logic              wrEn,
  input logic              wdtClear,
  input logic              sleepEnter,
  input logic              wdtTimeout,
  input logic [7:0]        statusOut,
  input logic [DATA_W-1:0] aluResult,
  input logic              bankSel
);

  logic zeroOp;
  assign zeroOp = (opClass == OP_ADD) || (opClass == OP_SUB) || (opClass == OP_AND) ||
                  (opClass == OP_OR)  || (opClass == OP_XOR) || (opClass == OP_CLR);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[7:6] == 2'b00);

  a_r3_bank_follows: assert property (@(posedge clk) disable iff (!rstN)
    bankSel == statusOut[BIT_RP0]);

  a_r4_power_bits_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wdtClear || sleepEnter || wdtTimeout) |=> $stable(statusOut[BIT_TO:BIT_PD]));

  a_r5_timeout_clears: assert property (@(posedge clk) disable iff (!rstN)
    wdtTimeout |=> !statusOut[BIT_TO]);

  a_r5_sleep_state: assert property (@(posedge clk) disable iff (!rstN)
    (sleepEnter && !wdtTimeout) |=> (statusOut[BIT_TO:BIT_PD] == 2'b10));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (aluValid && zeroOp) |=> (statusOut[BIT_Z] == $past(aluResult == '0)));

  a_r13_idle_flags: assert property (@(posedge clk) disable iff (!rstN)
    (!aluValid && !wrEn) |=> $stable(statusOut[BIT_Z:BIT_C]));

endmodule

bind statusFlagReg statusFlagChk #(.DATA_W(DATA_W)) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .opClass    (opClass),
  .aluValid   (aluValid),
  .wrEn       (wrEn),
  .wdtClear   (wdtClear),
  .sleepEnter (sleepEnter),
  .wdtTimeout (wdtTimeout),
  .statusOut  (statusOut),
  .aluResult  (aluResult),
  .bankSel    (bankSel)
);

// File: tb/statusFlagReg_test.sv
`timescale 1ns/1ps
module statusFlagReg_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opA = '0, opB = '0, wrData = '0;
  logic [3:0] opClass = '0;
  logic       aluValid = 1'b0, wrEn = 1'b0;
  logic       wdtClear = 1'b0, sleepEnter = 1'b0, wdtTimeout = 1'b0;
  logic [7:0] statusOut, aluResult;
  logic       bankSel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } itemT;
  itemT sbQ[$];

  // bench model of the status bits
  logic mRp0 = 1'b0, mTo = 1'b1, mPd = 1'b1, mZ = 1'b0, mDc = 1'b0, mC = 1'b0;

  always #10 clk = ~clk;

  statusFlagReg uut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opClass(opClass),
    .aluValid(aluValid), .wrEn(wrEn), .wrData(wrData),
    .wdtClear(wdtClear), .sleepEnter(sleepEnter), .wdtTimeout(wdtTimeout),
    .statusOut(statusOut), .aluResult(aluResult), .bankSel(bankSel)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op,
                      input logic v, input logic we, input logic [7:0] wd,
                      input logic clr, input logic slp, input logic tmo,
                      input string tag);
    logic [7:0] r;
    logic nc, ndc, aZ, aD, aC, anyF;
    itemT it;
    @(negedge clk);
    opA = a; opB = b; opClass = op; aluValid = v; wrEn = we; wrData = wd;
    wdtClear = clr; sleepEnter = slp; wdtTimeout = tmo;
    r = a; nc = mC; ndc = 1'b0; aZ = 1'b0; aD = 1'b0; aC = 1'b0;
    case (op)
      4'd1: begin r = a + b; nc = ({1'b0, a} + {1'b0, b}) > 9'd255;
                  ndc = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
                  aZ = 1; aD = 1; aC = 1; end
      4'd2: begin r = a - b; nc = (a >= b); ndc = (a[3:0] >= b[3:0]);
                  aZ = 1; aD = 1; aC = 1; end
      4'd3: begin r = {a[6:0], mC}; nc = a[7]; aC = 1; end
      4'd4: begin r = {mC, a[7:1]}; nc = a[0]; aC = 1; end
      4'd5: begin r = a & b; aZ = 1; end
      4'd6: begin r = a | b; aZ = 1; end
      4'd7: begin r = a ^ b; aZ = 1; end
      4'd8: begin r = 8'h00; aZ = 1; end
      default: r = a;
    endcase
    #1;
    check8({tag, " aluResult"}, aluResult, r);
    anyF = v & (aZ | aD | aC);
    if (v & aZ) mZ = (r == 8'h00); else if (we & ~anyF) mZ = wd[2];
    if (v & aD) mDc = ndc;         else if (we & ~anyF) mDc = wd[1];
    if (v & aC) mC = nc;           else if (we & ~anyF) mC = wd[0];
    if (we) mRp0 = wd[5];
    if (tmo) mTo = 1'b0; else if (clr | slp) mTo = 1'b1;
    if (slp) mPd = 1'b0; else if (clr) mPd = 1'b1;
    it.exp = {2'b00, mRp0, mTo, mPd, mZ, mDc, mC};
    it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk);
  endtask

  // monitor: compares each registered status against the queued expectation
  always @(posedge clk) begin
    itemT it;
    #2;
    if (sbQ.size() > 0) begin
      it = sbQ.pop_front();
      check8({it.tag, " status"}, statusOut, it.exp);
      total++;
      if (bankSel !== it.exp[5]) begin
        bad++;
        $display("FAIL %s bankSel: actual=%0b expected=%0b", it.tag, bankSel, it.exp[5]);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #45;
    check8("R1 reset status", statusOut, 8'h18);
    rstN = 1'b1;
    #10;
    check8("R1 status after release", statusOut, 8'h18);

    // writes with a move: all writable bits land, reserved and power bits do not
    step(8'h00, 8'h00, 4'd0, 1, 1, 8'hFF, 0, 0, 0, "R12 R2 R4 write all ones");
    step(8'h00, 8'h00, 4'd0, 0, 1, 8'hC0, 0, 0, 0, "R2 R3 reserved write");
    step(8'h00, 8'h00, 4'd0, 0, 1, 8'h20, 0, 0, 0, "R3 bank select set");
    step(8'h00, 8'h00, 4'd0, 0, 1, 8'h07, 0, 0, 0, "R12 R4 flag write");

    // add
    step(8'h0F, 8'h01, 4'd1, 1, 0, 8'h00, 0, 0, 0, "R7 add digit carry");
    step(8'hF0, 8'h10, 4'd1, 1, 0, 8'h00, 0, 0, 0, "R7 R6 add carry zero");
    step(8'h88, 8'h88, 4'd1, 1, 0, 8'h00, 0, 0, 0, "R7 add both carries");
    step(8'h12, 8'h34, 4'd1, 1, 0, 8'h00, 0, 0, 0, "R7 add no carry");

    // subtract
    step(8'h05, 8'h03, 4'd2, 1, 0, 8'h00, 0, 0, 0, "R8 sub no borrow");
    step(8'h03, 8'h05, 4'd2, 1, 0, 8'h00, 0, 0, 0, "R8 sub borrow");
    step(8'h10, 8'h01, 4'd2, 1, 0, 8'h00, 0, 0, 0, "R8 sub digit borrow");
    step(8'h42, 8'h42, 4'd2, 1, 0, 8'h00, 0, 0, 0, "R8 R6 sub equal");

    // rotates
    step(8'h81, 8'h00, 4'd3, 1, 0, 8'h00, 0, 0, 0, "R9 rotate left");
    step(8'h40, 8'h00, 4'd3, 1, 0, 8'h00, 0, 0, 0, "R9 rotate left carry in");
    step(8'h01, 8'h00, 4'd4, 1, 0, 8'h00, 0, 0, 0, "R9 rotate right");
    step(8'h02, 8'h00, 4'd4, 1, 0, 8'h00, 0, 0, 0, "R9 rotate right carry in");

    // logic and move
    step(8'h00, 8'h00, 4'd0, 0, 1, 8'h03, 0, 0, 0, "R12 preset carries");
    step(8'hF0, 8'h0F, 4'd5, 1, 0, 8'h00, 0, 0, 0, "R10 R6 and zero");
    step(8'hF0, 8'h0F, 4'd6, 1, 0, 8'h00, 0, 0, 0, "R10 or nonzero");
    step(8'h5A, 8'h5A, 4'd7, 1, 0, 8'h00, 0, 0, 0, "R10 xor zero");
    step(8'h00, 8'h00, 4'd0, 1, 0, 8'h00, 0, 0, 0, "R10 move no flags");

    // idle class presented without execution
    step(8'hFF, 8'h01, 4'd1, 0, 0, 8'h00, 0, 0, 0, "R13 add not executed");
    step(8'h33, 8'h33, 4'd2, 0, 0, 8'h00, 0, 0, 0, "R13 sub not executed");

    // masked writes
    step(8'h00, 8'h00, 4'd0, 0, 1, 8'h23, 0, 0, 0, "R12 preset bank and carries");
    step(8'h00, 8'h00, 4'd8, 1, 1, 8'h00, 0, 0, 0, "R11 clear to status");
    step(8'h01, 8'h01, 4'd1, 1, 1, 8'hFF, 0, 0, 0, "R11 add with write");
    step(8'h80, 8'h00, 4'd3, 1, 1, 8'h04, 0, 0, 0, "R11 rotate with write");
    step(8'h0F, 8'hF0, 4'd5, 1, 1, 8'h07, 0, 0, 0, "R11 and with write");

    // power events
    step(8'h00, 8'h00, 4'd0, 0, 0, 8'h00, 0, 1, 0, "R5 sleep");
    step(8'h00, 8'h00, 4'd0, 0, 1, 8'h18, 0, 0, 0, "R4 write power bits");
    step(8'h00, 8'h00, 4'd0, 0, 0, 8'h00, 1, 0, 0, "R5 watchdog clear");
    step(8'h00, 8'h00, 4'd0, 0, 0, 8'h00, 0, 0, 1, "R5 timeout");
    step(8'h00, 8'h00, 4'd0, 0, 1, 8'h10, 0, 0, 0, "R4 write to bit");
    step(8'h00, 8'h00, 4'd0, 0, 0, 8'h00, 1, 1, 0, "R5 clear and sleep");
    step(8'h00, 8'h00, 4'd0, 0, 0, 8'h00, 0, 1, 1, "R5 sleep and timeout");
    step(8'h00, 8'h00, 4'd0, 0, 0, 8'h00, 1, 0, 1, "R5 clear and timeout");
    step(8'h00, 8'h00, 4'd0, 0, 0, 8'h00, 1, 0, 0, "R5 clear restores");

    @(negedge clk);
    aluValid = 1'b0; wrEn = 1'b0; wdtClear = 1'b0; sleepEnter = 1'b0; wdtTimeout = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule